// File: doc/BRIEF.md
# Memory Request Address Router

The router classifies each physical memory request by its address and sends it to one destination: a DRAM channel, one of several PCI Express ports carrying memory-mapped space above the top of usable memory, a relocatable 1 KB register window of an on-chip DMA engine, a legacy I/O path, or master abort. It also marks whether the request needs a snoop of the other processor bus. A request is decoded against registered configuration, and the destination, DRAM channel and snoop flag appear one clock later together with a valid strobe.

Configuration sits behind a simple indexed write port. It holds the top of usable memory, the top of low memory, the top of extended SMM space, the DMA window base, a base/limit pair per port and a limit/channel pair per interleave range. A write that would leave the extended SMM top above the top of low memory is refused, and an error flag reports the outcome of the most recent write.

Decode is strictly priority ordered. First come the two fixed legacy windows below 1 MB. Then come, in turn, the DMA window, the hole from top of low memory to 4 GB, the per-port windows above top of memory, and the interleave ranges. Master abort catches whatever is left.

Top module: `mem_req_router`

## Requirements
- R1: When `req_valid` is high at a rising edge, `out_valid` is high after that edge with exactly one bit of `out_dest` set; when `req_valid` is low, `out_valid` and `out_dest` are zero after the edge. Destination bits: 0 DRAM, 1 legacy I/O, 2 DMA window, 3 master abort, 4+p PCI Express port p.
- R2: Addresses 0x0A_0000 to 0x0B_FFFF go to DRAM when `req_smm` is 1 and to legacy I/O when it is 0, with the snoop flag 0 and the channel 0. No other region takes precedence over this window.
- R3: Addresses 0x0C_0000 to 0x0F_FFFF go to DRAM for reads (`req_write` = 0) and to legacy I/O for writes, with the snoop flag 0 and the channel 0.
- R4: Outside the legacy windows, an address whose bits above bit 9 equal those of the DMA base goes to the DMA window, ahead of all later regions.
- R5: An address at or above the top of low memory and below 4 GB, not claimed by R2 to R4, is master-aborted and never goes to DRAM.
- R6: An address at or above the top of usable memory that lies within port p's base..limit (both inclusive) goes to port p; the lowest such p wins. A port window below the top of usable memory has no effect.
- R7: An address at or above the top of usable memory that hits no port window is master-aborted.
- R8: Any other address goes to DRAM on the channel of the lowest interleave range i with address < limit i; if no range matches, it is master-aborted.
- R9: The snoop flag is 1 for every DRAM destination except the two legacy windows, and 0 for every non-DRAM destination.
- R10: Config index map: 0 top of usable memory, 1 top of low memory, 2 extended SMM top, 3 DMA base (bits 9..0 forced to zero), 4+2p port p base, 5+2p port p limit, 4+2P+2i interleave i limit, 5+2P+2i interleave i channel (P = number of ports). A written value is used by requests from the next cycle on.
- R11: A write of the extended SMM top above the current top of low memory, or of the top of low memory below the current extended SMM top, is discarded; `cfg_err` becomes 1 after a discarded write and 0 after an accepted one.
- R12: After reset: top of usable memory 0x1_0000_0000, top of low memory 0xC000_0000, extended SMM top 0, DMA base 0xFE70_0000, every port base all ones and limit 0, every interleave limit and channel 0, `cfg_err` 0, `out_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Configuration register index |
| cfg_wdata | input | ADDR_W | Configuration write value |
| cfg_err | output | 1 | Most recent configuration write was refused |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request physical address |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_smm | input | 1 | Requester is in SMM mode |
| out_valid | output | 1 | Registered routing result present |
| out_dest | output | 4+N_PORTS | One-hot destination |
| out_chan | output | CH_W | DRAM channel, 0 for other destinations |
| out_snoop | output | 1 | Snoop of the other bus required |

## Verification
On every cycle the assertions check the valid latency and one-hot destination, that a snoop only accompanies DRAM, that the legacy windows never snoop, and that the low-memory hole never reaches DRAM. They also check that the extended SMM top never exceeds the top of low memory and that a refused write leaves the register untouched. The priority order between overlapping windows, the read/write split of the upper legacy window, the relocation of the DMA window, and first-match channel selection only show up in the bench. It sweeps boundary addresses across every SMM and direction combination against an arithmetic model and then rewrites the configuration to make windows overlap.

// File: rtl/mreq_route_pkg.sv
package mreq_route_pkg;

    // destination bit positions in the one-hot output
    localparam int DEST_DRAM   = 0;
    localparam int DEST_LEGACY = 1;
    localparam int DEST_DMA    = 2;
    localparam int DEST_ABORT  = 3;
    localparam int DEST_PORT0  = 4;
    localparam int NUM_FIXED_DEST = 4;

    // configuration index map
    localparam int REG_TOM   = 0;
    localparam int REG_TOLM  = 1;
    localparam int REG_ESMM  = 2;
    localparam int REG_DMA   = 3;
    localparam int REG_PORT0 = 4;

    localparam int DMA_WIN_BITS = 10;

    // reset values
    localparam logic [63:0] TOM_RST  = 64'h1_0000_0000;
    localparam logic [63:0] TOLM_RST = 64'h0_C000_0000;
    localparam logic [63:0] DMA_RST  = 64'h0_FE70_0000;
    localparam logic [63:0] FOUR_GB  = 64'h1_0000_0000;

    // fixed legacy windows below 1 MB
    localparam logic [63:0] SMM_LO  = 64'h0A_0000;
    localparam logic [63:0] SMM_HI  = 64'h0B_FFFF;
    localparam logic [63:0] BIOS_LO = 64'h0C_0000;
    localparam logic [63:0] BIOS_HI = 64'h0F_FFFF;

    typedef enum logic [2:0] {
        RG_LEG_SMM,
        RG_LEG_BIOS,
        RG_DMA,
        RG_HOLE,
        RG_HIGH,
        RG_MAIN
    } region_e;

    typedef struct packed {
        region_e region;
        logic    snoop;
    } route_t;

    function automatic logic in_span(input logic [63:0] a,
                                     input logic [63:0] lo,
                                     input logic [63:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/mr_first_hit.sv
module mr_first_hit #(
    parameter int N     = 2,
    parameter int SEL_W = 1
) (
    input  logic [N-1:0]     hit,
    output logic             found,
    output logic [SEL_W-1:0] sel
);
    always_comb begin
        sel = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (hit[k]) sel = SEL_W'(k);
        end
    end

    assign found = |hit;
endmodule

// File: rtl/mr_cfg_regs.sv
module mr_cfg_regs
    import mreq_route_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int N_PORTS = 2,
    parameter int N_IL    = 2,
    parameter int CH_W    = 2,
    parameter int IDX_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_we,
    input  logic [IDX_W-1:0]               cfg_idx,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    output logic                           cfg_err,
    output logic [ADDR_W-1:0]              tom_q,
    output logic [ADDR_W-1:0]              tolm_q,
    output logic [ADDR_W-1:0]              dma_q,
    output logic [N_PORTS-1:0][ADDR_W-1:0] pbase_q,
    output logic [N_PORTS-1:0][ADDR_W-1:0] plimit_q,
    output logic [N_IL-1:0][ADDR_W-1:0]    ilim_q,
    output logic [N_IL-1:0][CH_W-1:0]      ichan_q
);
    localparam int IL0 = REG_PORT0 + 2 * N_PORTS;
    localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'((64'd1 << DMA_WIN_BITS) - 64'd1);

    logic [ADDR_W-1:0] esmm_q;
    logic              bad_esmm, bad_tolm, refuse;

    assign bad_esmm = (cfg_idx == IDX_W'(REG_ESMM)) && (cfg_wdata > tolm_q);
    assign bad_tolm = (cfg_idx == IDX_W'(REG_TOLM)) && (cfg_wdata < esmm_q);
    assign refuse   = bad_esmm || bad_tolm;

    always_ff @(posedge clk) begin
        if (rst) begin
            tom_q    <= ADDR_W'(TOM_RST);
            tolm_q   <= ADDR_W'(TOLM_RST);
            esmm_q   <= '0;
            dma_q    <= ADDR_W'(DMA_RST);
            pbase_q  <= '1;
            plimit_q <= '0;
            ilim_q   <= '0;
            ichan_q  <= '0;
            cfg_err  <= 1'b0;
        end else if (cfg_we) begin
            cfg_err <= refuse;
            if (!refuse) begin
                if (cfg_idx == IDX_W'(REG_TOM))  tom_q  <= cfg_wdata;
                if (cfg_idx == IDX_W'(REG_TOLM)) tolm_q <= cfg_wdata;
                if (cfg_idx == IDX_W'(REG_ESMM)) esmm_q <= cfg_wdata;
                if (cfg_idx == IDX_W'(REG_DMA))  dma_q  <= cfg_wdata & WIN_MASK;
                for (int p = 0; p < N_PORTS; p++) begin
                    if (cfg_idx == IDX_W'(REG_PORT0 + 2 * p))     pbase_q[p]  <= cfg_wdata;
                    if (cfg_idx == IDX_W'(REG_PORT0 + 2 * p + 1)) plimit_q[p] <= cfg_wdata;
                end
                for (int i = 0; i < N_IL; i++) begin
                    if (cfg_idx == IDX_W'(IL0 + 2 * i))     ilim_q[i]  <= cfg_wdata;
                    if (cfg_idx == IDX_W'(IL0 + 2 * i + 1)) ichan_q[i] <= cfg_wdata[CH_W-1:0];
                end
            end
        end
    end

    // R11: the extended SMM top never sits above the top of low memory
    p_esmm_order_r11: assert property (@(posedge clk) disable iff (rst)
        esmm_q <= tolm_q);

    // R11: a refused extended SMM write flags an error and leaves the register alone
    p_esmm_refused_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx == IDX_W'(REG_ESMM) && cfg_wdata > tolm_q)
        |=> (cfg_err && $stable(esmm_q)));
endmodule

// File: rtl/mr_route_decode.sv
module mr_route_decode
    import mreq_route_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int N_PORTS = 2,
    parameter int N_IL    = 2,
    parameter int CH_W    = 2,
    parameter int DEST_W  = NUM_FIXED_DEST + N_PORTS
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           is_write,
    input  logic                           smm,
    input  logic [ADDR_W-1:0]              tom,
    input  logic [ADDR_W-1:0]              tolm,
    input  logic [ADDR_W-1:0]              dma_base,
    input  logic [N_PORTS-1:0][ADDR_W-1:0] pbase,
    input  logic [N_PORTS-1:0][ADDR_W-1:0] plimit,
    input  logic [N_IL-1:0][ADDR_W-1:0]    ilim,
    input  logic [N_IL-1:0][CH_W-1:0]      ichan,
    output logic [DEST_W-1:0]              dest,
    output logic [CH_W-1:0]                chan,
    output logic                           snoop
);
    localparam int PSEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam int ISEL_W = (N_IL > 1) ? $clog2(N_IL) : 1;
    localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'((64'd1 << DMA_WIN_BITS) - 64'd1);
    localparam logic [ADDR_W-1:0] TOP4G    = ADDR_W'(FOUR_GB);

    logic [N_PORTS-1:0] port_hit;
    logic [N_IL-1:0]    il_hit;
    logic               port_found, il_found;
    logic [PSEL_W-1:0]  port_sel;
    logic [ISEL_W-1:0]  il_sel;
    logic [63:0]        a64;
    route_t             rt;

    assign a64 = 64'(addr);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign port_hit[p] = (addr >= pbase[p]) && (addr <= plimit[p]);
    end

    for (genvar i = 0; i < N_IL; i++) begin : g_il
        assign il_hit[i] = addr < ilim[i];
    end

    mr_first_hit #(.N(N_PORTS), .SEL_W(PSEL_W)) u_port_pick (
        .hit(port_hit), .found(port_found), .sel(port_sel)
    );

    mr_first_hit #(.N(N_IL), .SEL_W(ISEL_W)) u_il_pick (
        .hit(il_hit), .found(il_found), .sel(il_sel)
    );

    // region classification in decode priority order
    always_comb begin
        if (in_span(a64, SMM_LO, SMM_HI))
            rt = '{region: RG_LEG_SMM, snoop: 1'b0};
        else if (in_span(a64, BIOS_LO, BIOS_HI))
            rt = '{region: RG_LEG_BIOS, snoop: 1'b0};
        else if ((addr & WIN_MASK) == dma_base)
            rt = '{region: RG_DMA, snoop: 1'b0};
        else if ((addr >= tolm) && (addr < TOP4G))
            rt = '{region: RG_HOLE, snoop: 1'b0};
        else if (addr >= tom)
            rt = '{region: RG_HIGH, snoop: 1'b0};
        else
            rt = '{region: RG_MAIN, snoop: il_found};
    end

    always_comb begin
        dest  = '0;
        chan  = '0;
        snoop = rt.snoop;
        case (rt.region)
            RG_LEG_SMM: begin
                if (smm) dest[DEST_DRAM]   = 1'b1;
                else     dest[DEST_LEGACY] = 1'b1;
            end
            RG_LEG_BIOS: begin
                if (is_write) dest[DEST_LEGACY] = 1'b1;
                else          dest[DEST_DRAM]   = 1'b1;
            end
            RG_DMA:  dest[DEST_DMA]   = 1'b1;
            RG_HOLE: dest[DEST_ABORT] = 1'b1;
            RG_HIGH: begin
                if (port_found) dest[DEST_PORT0 + int'(port_sel)] = 1'b1;
                else            dest[DEST_ABORT] = 1'b1;
            end
            default: begin
                if (il_found) begin
                    dest[DEST_DRAM] = 1'b1;
                    chan            = ichan[il_sel];
                end else begin
                    dest[DEST_ABORT] = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/mem_req_router.sv
module mem_req_router
    import mreq_route_pkg::*;
#(
    parameter  int ADDR_W  = 40,
    parameter  int N_PORTS = 2,
    parameter  int N_IL    = 2,
    parameter  int CH_W    = 2,
    localparam int IDX_W   = $clog2(REG_PORT0 + 2 * N_PORTS + 2 * N_IL),
    localparam int DEST_W  = NUM_FIXED_DEST + N_PORTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              cfg_err,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_smm,
    output logic              out_valid,
    output logic [DEST_W-1:0] out_dest,
    output logic [CH_W-1:0]   out_chan,
    output logic              out_snoop
);
    logic [ADDR_W-1:0]              tom_q, tolm_q, dma_q;
    logic [N_PORTS-1:0][ADDR_W-1:0] pbase_q, plimit_q;
    logic [N_IL-1:0][ADDR_W-1:0]    ilim_q;
    logic [N_IL-1:0][CH_W-1:0]      ichan_q;
    logic [DEST_W-1:0]              dest_d;
    logic [CH_W-1:0]                chan_d;
    logic                           snoop_d;

    mr_cfg_regs #(
        .ADDR_W(ADDR_W), .N_PORTS(N_PORTS), .N_IL(N_IL), .CH_W(CH_W), .IDX_W(IDX_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .tom_q(tom_q), .tolm_q(tolm_q), .dma_q(dma_q),
        .pbase_q(pbase_q), .plimit_q(plimit_q),
        .ilim_q(ilim_q), .ichan_q(ichan_q)
    );

    mr_route_decode #(
        .ADDR_W(ADDR_W), .N_PORTS(N_PORTS), .N_IL(N_IL), .CH_W(CH_W), .DEST_W(DEST_W)
    ) u_dec (
        .addr(req_addr), .is_write(req_write), .smm(req_smm),
        .tom(tom_q), .tolm(tolm_q), .dma_base(dma_q),
        .pbase(pbase_q), .plimit(plimit_q),
        .ilim(ilim_q), .ichan(ichan_q),
        .dest(dest_d), .chan(chan_d), .snoop(snoop_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_dest  <= '0;
            out_chan  <= '0;
            out_snoop <= 1'b0;
        end else begin
            out_valid <= req_valid;
            out_dest  <= req_valid ? dest_d : '0;
            out_chan  <= req_valid ? chan_d : '0;
            out_snoop <= req_valid && snoop_d;
        end
    end

    // R1: one-cycle result latency
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R1: no result without a request
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && out_dest == '0));

    // R1: exactly one destination per result
    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_dest) == 1));

    // R9: snoop only on DRAM traffic
    p_snoop_dram_r9: assert property (@(posedge clk) disable iff (rst)
        out_snoop |-> out_dest[DEST_DRAM]);

    // R2, R3: legacy windows below 1 MB never snoop
    p_legacy_nosnoop_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && 64'(req_addr) >= SMM_LO && 64'(req_addr) <= BIOS_HI)
        |=> !out_snoop);

    // R5: the hole below 4 GB never reaches DRAM
    p_hole_no_dram_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr >= tolm_q && 64'(req_addr) < FOUR_GB
         && 64'(req_addr) > BIOS_HI)
        |=> !out_dest[DEST_DRAM]);
endmodule

// File: tb/mem_req_router_tb.sv
module mem_req_router_tb;
    localparam int AW = 40;
    localparam int NP = 2;
    localparam int NI = 2;
    localparam int CW = 2;
    localparam int IW = 4;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          cfg_err;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_smm = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_dest;
    logic [CW-1:0] out_chan;
    logic          out_snoop;

    int total = 0;
    int bad   = 0;

    // bench-side copy of the configuration as the requirements define it
    logic [AW-1:0] m_tom, m_tolm, m_esmm, m_dma;
    logic [AW-1:0] m_pb [NP];
    logic [AW-1:0] m_pl [NP];
    logic [AW-1:0] m_il [NI];
    logic [CW-1:0] m_ic [NI];
    logic          m_err;

    mem_req_router #(.ADDR_W(AW), .N_PORTS(NP), .N_IL(NI), .CH_W(CW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_smm(req_smm), .out_valid(out_valid), .out_dest(out_dest),
        .out_chan(out_chan), .out_snoop(out_snoop)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tom  = 40'h1_0000_0000;
        m_tolm = 40'h0_C000_0000;
        m_esmm = '0;
        m_dma  = 40'h0_FE70_0000;
        for (int p = 0; p < NP; p++) begin m_pb[p] = '1; m_pl[p] = '0; end
        for (int i = 0; i < NI; i++) begin m_il[i] = '0; m_ic[i] = '0; end
        m_err = 1'b0;
    endtask

    task automatic cfg_write(input int idx, input logic [AW-1:0] data);
        logic refuse;
        refuse = (idx == 2 && data > m_tolm) || (idx == 1 && data < m_esmm);
        m_err = refuse;
        if (!refuse) begin
            case (idx)
                0: m_tom  = data;
                1: m_tolm = data;
                2: m_esmm = data;
                3: m_dma  = {data[AW-1:10], 10'd0};
                4: m_pb[0] = data;
                5: m_pl[0] = data;
                6: m_pb[1] = data;
                7: m_pl[1] = data;
                8: m_il[0] = data;
                9: m_ic[0] = data[CW-1:0];
                10: m_il[1] = data;
                11: m_ic[1] = data[CW-1:0];
                default: ;
            endcase
        end
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_idx = IW'(idx);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // expected destination from the requirement text: bits 0 DRAM, 1 legacy, 2 DMA, 3 abort, 4+p port
    task automatic expect_route(input logic [AW-1:0] a, input logic wr, input logic smm,
                                output logic [DW-1:0] d, output logic [CW-1:0] c,
                                output logic s, output string tag);
        d = '0; c = '0; s = 1'b0;
        if (a >= 40'h0A_0000 && a <= 40'h0B_FFFF) begin
            d[smm ? 0 : 1] = 1'b1; tag = "R2";
        end else if (a >= 40'h0C_0000 && a <= 40'h0F_FFFF) begin
            d[wr ? 1 : 0] = 1'b1; tag = "R3";
        end else if (a[AW-1:10] == m_dma[AW-1:10]) begin
            d[2] = 1'b1; tag = "R4";
        end else if (a >= m_tolm && a < 40'h1_0000_0000) begin
            d[3] = 1'b1; tag = "R5";
        end else if (a >= m_tom) begin
            if (a >= m_pb[0] && a <= m_pl[0]) begin d[4] = 1'b1; tag = "R6"; end
            else if (a >= m_pb[1] && a <= m_pl[1]) begin d[5] = 1'b1; tag = "R6"; end
            else begin d[3] = 1'b1; tag = "R7"; end
        end else begin
            tag = "R8";
            if (a < m_il[0]) begin d[0] = 1'b1; c = m_ic[0]; s = 1'b1; end
            else if (a < m_il[1]) begin d[0] = 1'b1; c = m_ic[1]; s = 1'b1; end
            else d[3] = 1'b1;
        end
    endtask

    task automatic send(input logic [AW-1:0] a, input logic wr, input logic smm,
                        input string note);
        logic [DW-1:0] d;
        logic [CW-1:0] c;
        logic s;
        string tag;
        expect_route(a, wr, smm, d, c, s, tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_smm = smm;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " dest ", note}, 64'(out_dest), 64'(d));
        chk({tag, " chan ", note}, 64'(out_chan), 64'(c));
        chk({"R9 snoop ", note}, 64'(out_snoop), 64'(s));
    endtask

    logic [AW-1:0] sweep [24];

    initial begin
        sweep = '{40'h0, 40'h9_FFFF, 40'hA_0000, 40'hB_FFFF, 40'hC_0000, 40'hF_FFFF,
                  40'h10_0000, 40'h7FFF_FFFF, 40'h8000_0000, 40'hBFFF_FFFF,
                  40'hC000_0000, 40'hFE6F_FFFF, 40'hFE70_0000, 40'hFE70_03FF,
                  40'hFE70_0400, 40'hFFFF_FFFF, 40'h1_0000_0000, 40'h1_FFFF_FFFF,
                  40'h2_0000_0000, 40'h2_0FFF_FFFF, 40'h2_1000_0000, 40'h2_1FFF_FFFF,
                  40'h2_2000_0000, 40'hFF_FFFF_FFFF};
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        chk("R12 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R12 cfg_err after reset", 64'(cfg_err), 64'd0);
        chk("R12 out_dest after reset", 64'(out_dest), 64'd0);
        send(40'hFE70_0010, 1'b0, 1'b0, "R12 default DMA base");
        send(40'h1000, 1'b0, 1'b0, "R12 no interleave range");
        send(40'h1_0000_0000, 1'b0, 1'b0, "R12 default top of memory");

        // R1: valid follows the request by one cycle and drops with it
        @(negedge clk);
        req_valid = 1'b1; req_addr = 40'h5000;
        @(negedge clk);
        chk("R1 valid one cycle later", 64'(out_valid), 64'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 valid low after idle", 64'(out_valid), 64'd0);
        chk("R1 dest zero after idle", 64'(out_dest), 64'd0);

        // R10: program a full configuration
        cfg_write(0, 40'h2_0000_0000);
        cfg_write(4, 40'h2_0000_0000);
        cfg_write(5, 40'h2_0FFF_FFFF);
        cfg_write(6, 40'h2_1000_0000);
        cfg_write(7, 40'h2_1FFF_FFFF);
        cfg_write(8, 40'h8000_0000);
        cfg_write(9, 40'h1);
        cfg_write(10, 40'h2_0000_0000);
        cfg_write(11, 40'h2);

        // sweep of boundary addresses over all direction and SMM combinations
        for (int k = 0; k < 24; k++) begin
            for (int m = 0; m < 4; m++) begin
                send(sweep[k], m[0], m[1], "sweep");
            end
        end

        // R4 and R10: relocate the DMA window into main memory, unaligned write
        cfg_write(3, 40'h20_0123);
        send(40'h20_0000, 1'b0, 1'b0, "R4 relocated window base");
        send(40'h20_03FF, 1'b1, 1'b0, "R4 relocated window top");
        send(40'h20_0400, 1'b0, 1'b0, "R10 just past relocated window");
        send(40'hFE70_0000, 1'b0, 1'b0, "R10 old window now hole");
        // R2 priority over the DMA window
        cfg_write(3, 40'hA_0000);
        send(40'hA_0010, 1'b0, 1'b0, "R2 legacy beats DMA");
        send(40'hA_0010, 1'b0, 1'b1, "R2 legacy beats DMA in SMM");

        // R6: overlapping ports pick the lowest, and a port below top of memory is ignored
        cfg_write(6, 40'h1000);
        send(40'h2_0000_0010, 1'b0, 1'b0, "R6 overlap lowest port wins");
        send(40'h1800, 1'b0, 1'b0, "R6 port window below top ignored");

        // R8: no interleave range matches below top of memory
        cfg_write(10, 40'h1_8000_0000);
        send(40'h1_C000_0000, 1'b0, 1'b0, "R8 beyond last limit");
        send(40'h1_7FFF_FFFF, 1'b0, 1'b0, "R8 last range top");

        // R11: refused and accepted writes
        cfg_write(2, 40'hD000_0000);
        chk("R11 err after refused SMM top", 64'(cfg_err), 64'(m_err));
        cfg_write(2, 40'h7000_0000);
        chk("R11 err clears after accepted write", 64'(cfg_err), 64'd0);
        cfg_write(1, 40'h6000_0000);
        chk("R11 err after refused low-memory top", 64'(cfg_err), 64'd1);
        send(40'h6800_0000, 1'b0, 1'b0, "R11 low-memory top unchanged");
        cfg_write(1, 40'h7800_0000);
        chk("R11 lower top of low memory accepted", 64'(cfg_err), 64'd0);
        send(40'h7900_0000, 1'b0, 1'b0, "R5 lowered hole start");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule